// File: doc/BRIEF.md
# Approximate Multiplier with Complemented Partial Products

This block is an unsigned, purely combinational multiplier that trades a bounded amount of accuracy in the low-order part of the product for a cheaper reduction network. Every partial-product bit is produced in complemented form by a NAND of one bit of each operand. The whole reduction tree then works on complemented values, which means it counts zeros rather than ones. Each reduction cell takes complemented bits and returns complemented bits.

A design-time parameter `M` gives the number of low-order columns that are reduced with approximate cells. The approximate cells are a four-input compressor with no lateral carry and a three-input OR/AND cell. Columns at and above `M` are reduced with exact full adders. The last two rows are merged in two ways. Below column `M` the merge is a carry-free OR per bit. From column `M` upward it is an exact lookahead adder that accepts complemented operands and returns true product bits. Its carry-in is a compensation term taken from the last two approximate columns. A larger `M` gives a smaller and shorter tree, at the cost of more error.

Top module: `napm_mul`

## Requirements
- R1: When either operand is zero the product is zero.
- R2: When either operand has at most one bit set, the product equals the exact product a*b.
- R3: Column c of the first level holds the products a[i]&b[c-i] as slots, ordered by ascending i. In an approximate column (c < M), slots are taken four at a time from slot 0 upward. Each group (p,q,r,s) yields sum = p|q|r|s in column c and carry = (p&q)|(r&s) in column c+1. For example, ones in slots p and r give 1 rather than 2.
- R4: In an approximate column, if three slots remain after the groups of four, they form a cell with sum = OR and carry = AND. If one or two slots remain, they pass through unchanged.
- R5: In an exact column (c >= M), slots are taken three at a time from slot 0 upward and fed to full adders. Any one or two slots left over pass through unchanged.
- R6: Each level's output column c lists, in order: the sums of its own cells, then its passed slots, then the carries from column c-1. Carries leaving the top column are discarded. The tree has six levels (parameter LEVELS).
- R7: Below column M, each product bit is the OR of the two bits left in that column after the last level, and no carry moves between these columns. For example, 3*3 gives 7.
- R8: Columns M and above are the exact sum of the two remaining rows plus a carry-in at weight 2^M. That carry-in is (x1&x2)|(x3&x4), where x1,x2 are the remaining bits of column M-2 and x3,x4 those of column M-1. The result is taken modulo 2^16.
- R9: Product bit 0 equals a[0]&b[0], and bit 1 equals (a[0]&b[1])|(a[1]&b[0]).
- R10: M is a design-time parameter from 7 to 13, and the two ends of that range give different results on some operand pairs.
- R11: Product bit 2 equals the OR of a[0]&b[2], a[1]&b[1] and a[2]&b[0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 (W) | Multiplicand, unsigned |
| b | input | 8 (W) | Multiplier, unsigned |
| product | output | 16 (2*W) | Approximate product |

## Verification
The block has no register between its operands and its product, so every result is due in the same cycle as its stimulus. The bench changes the operands just after a rising edge and reads the product at the next falling edge, half a period later. Expected values come from a column-by-column model written in true (non-complemented) values from R3 to R8. Two instances, one with M=7 and one with M=13, are swept over all operand pairs. Hand-worked cases cover zero and single-bit operands, the carry-free low bits and a split-pair compressor case.

// File: rtl/napm_pkg.sv
// Package: compile-time geometry of the complemented reduction tree.
// Assumes column heights never exceed W slots at any level for 7 <= M <= 13.
package napm_pkg;

    localparam int MAX_COLS = 64;

    // Height of column c in the initial partial-product array.
    function automatic int pp_height(input int w, input int c);
        if (c < 0 || c >= 2 * w - 1) return 0;
        if (c < w) return c + 1;
        return 2 * w - 1 - c;
    endfunction

    // Lowest row index that feeds column c.
    function automatic int pp_row0(input int w, input int c);
        return (c > w - 1) ? c - w + 1 : 0;
    endfunction

    // Number of reduction cells placed in a column of height h.
    function automatic int grp_count(input int h, input bit apx);
        if (apx) return h / 4 + (((h % 4) == 3) ? 1 : 0);
        return h / 3;
    endfunction

    // Number of slots passed through unchanged in a column of height h.
    function automatic int pass_count(input int h, input bit apx);
        if (apx) return ((h % 4) == 3) ? 0 : (h % 4);
        return h % 3;
    endfunction

    // Height of column c at the input of level lvl.
    function automatic int col_height(input int w, input int m, input int lvl, input int c);
        int h  [MAX_COLS];
        int nh [MAX_COLS];
        if (c < 0 || c >= 2 * w) return 0;
        for (int cc = 0; cc < 2 * w; cc++) h[cc] = pp_height(w, cc);
        for (int l = 0; l < lvl; l++) begin
            for (int cc = 0; cc < 2 * w; cc++) begin
                nh[cc] = grp_count(h[cc], cc < m) + pass_count(h[cc], cc < m);
                if (cc > 0) nh[cc] = nh[cc] + grp_count(h[cc-1], (cc - 1) < m);
            end
            for (int cc = 0; cc < 2 * w; cc++) h[cc] = nh[cc];
        end
        return h[c];
    endfunction

endpackage

// File: rtl/napm_cells.sv
// Approximate 4:2 cell on complemented bits; no lateral carry.
// Assumes x_n holds complemented bits p,q,r,s in slots 0..3.
module napm_a42n (
    input  logic [3:0] x_n,
    output logic       s_n,
    output logic       c_n
);
    // Sum: complemented OR of all four is the AND of complements.
    assign s_n = &x_n;
    // Carry: complemented (p&q)|(r&s), built from NOR pairs.
    assign c_n = ~(~(x_n[0] | x_n[1]) | ~(x_n[2] | x_n[3]));
endmodule

// Approximate 3-input cell on complemented bits: sum = OR, carry = AND.
module napm_a3n (
    input  logic [2:0] x_n,
    output logic       s_n,
    output logic       c_n
);
    // Sum and carry, both complemented.
    assign s_n = &x_n;
    assign c_n = |x_n;
endmodule

// Exact full adder; self-dual, so it works unchanged on complemented bits.
module napm_fan (
    input  logic [2:0] x_n,
    output logic       s_n,
    output logic       c_n
);
    // Parity sum and majority carry.
    assign s_n = ^x_n;
    assign c_n = (x_n[0] & x_n[1]) | (x_n[0] & x_n[2]) | (x_n[1] & x_n[2]);
endmodule

// File: rtl/napm_level.sv
// One reduction level. Columns below M use approximate cells, the rest exact
// full adders. Output column order: own sums, passed slots, carries from below.
// Assumes slots above a column's height carry complemented zero (1).
module napm_level #(
    parameter int W   = 8,
    parameter int M   = 7,
    parameter int LVL = 0
) (
    input  logic [2*W-1:0][W-1:0] cols_n,
    output logic [2*W-1:0][W-1:0] nxt_n
);
    import napm_pkg::*;

    localparam int NCOL  = 2 * W;
    localparam int SLOTS = W;

    logic [NCOL-1:0][SLOTS-1:0] sm_n;
    logic [NCOL-1:0][SLOTS-1:0] cy_n;

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        localparam bit APX = (c < M);
        localparam int H   = col_height(W, M, LVL, c);
        localparam int NG  = grp_count(H, APX);
        localparam int NP  = pass_count(H, APX);
        localparam int NGB = grp_count(col_height(W, M, LVL, c - 1), (c - 1) < M);

        // Cell placement: one cell per group, idle slots tied to complemented zero.
        for (genvar g = 0; g < SLOTS; g++) begin : g_cell
            if (g < NG) begin : g_used
                if (APX && (g < H / 4)) begin : g_a42
                    napm_a42n u_cell (.x_n(cols_n[c][4*g +: 4]), .s_n(sm_n[c][g]), .c_n(cy_n[c][g]));
                end else if (APX) begin : g_a3
                    napm_a3n u_cell (.x_n(cols_n[c][4*(H/4) +: 3]), .s_n(sm_n[c][g]), .c_n(cy_n[c][g]));
                end else begin : g_fa
                    napm_fan u_cell (.x_n(cols_n[c][3*g +: 3]), .s_n(sm_n[c][g]), .c_n(cy_n[c][g]));
                end
            end else begin : g_idle
                assign sm_n[c][g] = 1'b1;
                assign cy_n[c][g] = 1'b1;
            end
        end

        // Routing of the next-level column.
        for (genvar k = 0; k < SLOTS; k++) begin : g_route
            if (k < NG) begin : g_sum
                assign nxt_n[c][k] = sm_n[c][k];
            end else if (k < NG + NP) begin : g_pass
                assign nxt_n[c][k] = cols_n[c][H - NP + (k - NG)];
            end else if (k < NG + NP + NGB) begin : g_carry
                assign nxt_n[c][k] = cy_n[c-1][k - NG - NP];
            end else begin : g_empty
                assign nxt_n[c][k] = 1'b1;
            end
        end
    end

    // Slots outside the active heights are intentionally left unread.
    logic unused_lvl;
    assign unused_lvl = ^{cols_n, sm_n, cy_n};

endmodule

// File: rtl/napm_cla.sv
// Exact lookahead adder taking complemented operands, returning true sum bits.
// Generate terms come from NOR of the complemented inputs.
module napm_cla #(
    parameter int N = 9
) (
    input  logic [N-1:0] x_n,
    input  logic [N-1:0] y_n,
    input  logic         cin,
    output logic [N-1:0] sum
);
    logic [N-1:0] gen;
    logic [N-1:0] prp;
    logic [N-1:0] cv;

    // Per-bit generate (NOR) and propagate (NAND) on complemented inputs.
    assign gen = ~(x_n | y_n);
    assign prp = ~(x_n & y_n);

    // Flat lookahead: each carry as an OR of generate-and-propagate products.
    always_comb begin
        logic pr;
        for (int i = 0; i < N; i++) begin
            pr = 1'b1;
            for (int k = 0; k < i; k++) pr = pr & prp[k];
            cv[i] = cin & pr;
            for (int j = 0; j < i; j++) begin
                pr = 1'b1;
                for (int k = j + 1; k < i; k++) pr = pr & prp[k];
                cv[i] = cv[i] | (gen[j] & pr);
            end
        end
    end

    // True sum: complemented XOR equals true XOR.
    assign sum = x_n ^ y_n ^ cv;

endmodule

// File: rtl/napm_final.sv
// Final merge: carry-free OR below column M, exact adder from column M up,
// with a compensation carry drawn from columns M-2 and M-1.
// Assumes at most two live slots (0 and 1) per column.
module napm_final #(
    parameter int W = 8,
    parameter int M = 7
) (
    input  logic [2*W-1:0][W-1:0] cols_n,
    output logic [2*W-1:0]        product
);
    localparam int NCOL = 2 * W;
    localparam int HW   = NCOL - M;

    logic          nor_lo;
    logic          nor_hi;
    logic          fix_n;
    logic [HW-1:0] hx_n;
    logic [HW-1:0] hy_n;

    // Low bits: true OR of the two rows, no carry.
    for (genvar c = 0; c < M; c++) begin : g_low
        assign product[c] = ~(cols_n[c][0] & cols_n[c][1]);
    end

    // Compensation: three 2-input NORs on complemented bits.
    assign nor_lo = ~(cols_n[M-2][0] | cols_n[M-2][1]);
    assign nor_hi = ~(cols_n[M-1][0] | cols_n[M-1][1]);
    assign fix_n  = ~(nor_lo | nor_hi);

    // Operand rows of the exact section.
    for (genvar i = 0; i < HW; i++) begin : g_high
        assign hx_n[i] = cols_n[M+i][0];
        assign hy_n[i] = cols_n[M+i][1];
    end

    napm_cla #(.N(HW)) u_cla (
        .x_n (hx_n),
        .y_n (hy_n),
        .cin (~fix_n),
        .sum (product[NCOL-1:M])
    );

    logic unused_fin;
    assign unused_fin = ^cols_n;

endmodule

// File: rtl/napm_mul.sv
// Top: unsigned W x W approximate multiplier on complemented partial products.
// Combinational; M low columns approximate, LEVELS reduction levels.
module napm_mul #(
    parameter int W      = 8,
    parameter int M      = 7,
    parameter int LEVELS = 6
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] product
);
    import napm_pkg::*;

    localparam int NCOL = 2 * W;

    logic [LEVELS:0][NCOL-1:0][W-1:0] stage_n;

    // Partial products: NAND of operand bits, slots ordered by ascending row.
    for (genvar c = 0; c < NCOL; c++) begin : g_pp
        for (genvar k = 0; k < W; k++) begin : g_slot
            if (k < pp_height(W, c)) begin : g_live
                assign stage_n[0][c][k] = ~(a[pp_row0(W, c) + k] & b[c - pp_row0(W, c) - k]);
            end else begin : g_pad
                assign stage_n[0][c][k] = 1'b1;
            end
        end
    end

    // Reduction levels chained in sequence.
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        napm_level #(.W(W), .M(M), .LVL(l)) u_level (
            .cols_n (stage_n[l]),
            .nxt_n  (stage_n[l+1])
        );
    end

    napm_final #(.W(W), .M(M)) u_final (
        .cols_n  (stage_n[LEVELS]),
        .product (product)
    );

endmodule

// File: rtl/napm_mul_chk.sv
// Checker: port-level properties of the multiplier, bound to every instance.
// Assumes W >= 3 and M >= 3.
module napm_mul_chk #(
    parameter int W = 8
) (
    input logic [W-1:0]   a,
    input logic [W-1:0]   b,
    input logic [2*W-1:0] product
);
    // Immediate checks on the combinational result.
    always_comb begin
        AST_ZERO_OPERAND: assert (!((a == '0) || (b == '0)) || (product == '0)); // R1
        AST_SINGLE_BIT_EXACT: assert (!(($countones(a) <= 1) || ($countones(b) <= 1))
                                      || (product == ({{W{1'b0}}, a} * {{W{1'b0}}, b}))); // R2
        AST_BIT0: assert (product[0] == (a[0] & b[0])); // R9
        AST_BIT1: assert (product[1] == ((a[0] & b[1]) | (a[1] & b[0]))); // R9
        AST_BIT2_OR: assert (product[2] == ((a[0] & b[2]) | (a[1] & b[1]) | (a[2] & b[0]))); // R11
    end
endmodule

bind napm_mul napm_mul_chk #(.W(W)) u_chk (.a(a), .b(b), .product(product));

// File: tb/test_napm_mul.sv
`timescale 1ns/1ps
module test_napm_mul;

    logic        clk = 1'b0;
    logic [7:0]  a = 8'd0;
    logic [7:0]  b = 8'd0;
    logic [15:0] p7;
    logic [15:0] p13;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;

    always #2 clk = ~clk;

    napm_mul #(.W(8), .M(7))  i_napm_mul     (.a(a), .b(b), .product(p7));
    napm_mul #(.W(8), .M(13)) i_napm_mul_m13 (.a(a), .b(b), .product(p13));

    // Column model in true values, built from R3..R8.
    function automatic int ref_mul(input int av, input int bv, input int m);
        int col [16][8];
        int nc  [16][8];
        int cy  [16][8];
        int h   [16];
        int nh  [16];
        int ncy [16];
        int res;
        int hi;
        int corr;
        int x [4];
        for (int c = 0; c < 16; c++) begin
            h[c] = 0;
            for (int i = 0; i < 8; i++) begin
                int j;
                j = c - i;
                if (j >= 0 && j < 8) begin
                    col[c][h[c]] = ((av >> i) & 1) & ((bv >> j) & 1);
                    h[c] = h[c] + 1;
                end
            end
        end
        for (int l = 0; l < 6; l++) begin
            for (int c = 0; c < 16; c++) begin
                nh[c] = 0;
                ncy[c] = 0;
                if (c < m) begin
                    for (int g = 0; g < h[c] / 4; g++) begin
                        for (int k = 0; k < 4; k++) x[k] = col[c][4*g+k];
                        nc[c][nh[c]] = x[0] | x[1] | x[2] | x[3];
                        nh[c] = nh[c] + 1;
                        cy[c][ncy[c]] = (x[0] & x[1]) | (x[2] & x[3]);
                        ncy[c] = ncy[c] + 1;
                    end
                    if (h[c] % 4 == 3) begin
                        for (int k = 0; k < 3; k++) x[k] = col[c][h[c]-3+k];
                        nc[c][nh[c]] = x[0] | x[1] | x[2];
                        nh[c] = nh[c] + 1;
                        cy[c][ncy[c]] = x[0] & x[1] & x[2];
                        ncy[c] = ncy[c] + 1;
                    end else begin
                        for (int k = h[c] - h[c] % 4; k < h[c]; k++) begin
                            nc[c][nh[c]] = col[c][k];
                            nh[c] = nh[c] + 1;
                        end
                    end
                end else begin
                    for (int g = 0; g < h[c] / 3; g++) begin
                        int t;
                        t = col[c][3*g] + col[c][3*g+1] + col[c][3*g+2];
                        nc[c][nh[c]] = t & 1;
                        nh[c] = nh[c] + 1;
                        cy[c][ncy[c]] = t >> 1;
                        ncy[c] = ncy[c] + 1;
                    end
                    for (int k = h[c] - h[c] % 3; k < h[c]; k++) begin
                        nc[c][nh[c]] = col[c][k];
                        nh[c] = nh[c] + 1;
                    end
                end
            end
            for (int c = 1; c < 16; c++) begin
                for (int k = 0; k < ncy[c-1]; k++) begin
                    nc[c][nh[c]] = cy[c-1][k];
                    nh[c] = nh[c] + 1;
                end
            end
            for (int c = 0; c < 16; c++) begin
                h[c] = nh[c];
                for (int k = 0; k < 8; k++) col[c][k] = (k < nh[c]) ? nc[c][k] : 0;
            end
        end
        res = 0;
        for (int c = 0; c < m; c++) res = res | ((col[c][0] | col[c][1]) << c);
        corr = (col[m-2][0] & col[m-2][1]) | (col[m-1][0] & col[m-1][1]);
        hi = corr << m;
        for (int c = m; c < 16; c++) hi = hi + ((col[c][0] + col[c][1]) << c);
        return (res + hi) & 16'hFFFF;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, got, exp);
        end
    endtask

    // Drive just after the rising edge; result is sampled at the falling edge.
    task automatic apply(input int av, input int bv);
        @(posedge clk);
        a = av[7:0];
        b = bv[7:0];
        @(negedge clk);
    endtask

    task automatic t_initial();
        apply(0, 0);
        check("R1 initial m7", p7, 0);
        check("R1 initial m13", p13, 0);
    endtask

    task automatic t_zero();
        int vals [4] = '{1, 77, 200, 255};
        foreach (vals[i]) begin
            apply(0, vals[i]);
            check("R1 a=0 m7", p7, 0);
            check("R1 a=0 m13", p13, 0);
            apply(vals[i], 0);
            check("R1 b=0 m7", p7, 0);
            check("R1 b=0 m13", p13, 0);
        end
    endtask

    task automatic t_single_bit();
        for (int k = 0; k < 8; k++) begin
            for (int v = 0; v < 256; v += 37) begin
                apply(1 << k, v);
                check("R2 power-of-two a m7", p7, (1 << k) * v);
                check("R2 power-of-two a m13", p13, (1 << k) * v);
                apply(v, 1 << k);
                check("R2 power-of-two b m7", p7, (1 << k) * v);
            end
        end
        apply(255, 128);
        check("R2 255x128 m13", p13, 255 * 128);
    endtask

    task automatic t_low_bits();
        apply(3, 3);
        check("R7 3x3 carry-free m7", p7, 7);
        check("R7 3x3 carry-free m13", p13, 7);
        apply(6, 5);
        check("R9 bit0 6x5", int'(p7[0]), 0);
        check("R9 bit1 6x5", int'(p7[1]), 1);
        check("R11 bit2 6x5", int'(p7[2]), 1);
    endtask

    task automatic t_split_pair();
        apply(33, 33);
        check("R3 split pair 33x33 m7", p7, 1057);
        check("R6 slot order 33x33 model", ref_mul(33, 33, 7), 1057);
    endtask

    task automatic t_sweep();
        int diff = 0;
        for (int av = 0; av < 256; av++) begin
            for (int bv = 0; bv < 256; bv++) begin
                apply(av, bv);
                check("R3/R4/R5/R6/R8 sweep m7", p7, ref_mul(av, bv, 7));
                check("R3/R4/R5/R6/R8 sweep m13", p13, ref_mul(av, bv, 13));
                if (p7 != p13) diff++;
            end
        end
        checks++;
        if (diff == 0) begin
            fails++;
            $display("FAIL R10 differing pairs actual=%0d expected=>0", diff);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_initial();
        t_zero();
        t_single_bit();
        t_low_bits();
        t_split_pair();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule